// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Bank

This block holds the digital state behind a four-channel 12-bit converter. Every channel has two levels of storage: a staging register, which a write can fill without touching the output, and an active register that drives the channel's output code and power-down setting. Besides the 12-bit code, each level holds a 2-bit power-down mode.

A serial front end decodes a transfer into one write strobe. The strobe carries a control byte, a high data byte and a low data byte. The control byte chooses one of four load modes and a target channel, and it carries two extended address bits that must match two strap pins. The bank applies the write in the clock cycle of the strobe. Every channel that the write touches changes on the same edge.

Control byte bits, from bit 7 down to bit 0: address bit A3, address bit A2, mode bit 1, mode bit 0, a spare bit, select bit 1, select bit 0, and the power-down flag. A power-down mode of 00 means normal operation. Any other value marks the channel as powered down.

Top module: `quad_dac_regbank`

## Requirements
- R1: After reset, and whenever reset is asserted, every staging and active register holds code 0 and power-down mode 00. All outputs then read zero.
- R2: In modes 00, 01 and 10, a write whose control bits [7:6] differ from `strapAddr` changes nothing. Mode 11 ignores this check.
- R3: Mode 00 (control bits [5:4] = 00) writes only the staging register of the selected channel, and all outputs stay unchanged. Control bits [2:1] select the channel: 00 is channel 0, 01 is channel 1, 10 is channel 2 and 11 is channel 3.
- R4: Mode 01 writes the selected channel's staging register and active register with the new value. The output of that channel changes after the strobe.
- R5: Mode 10 writes the new value into the selected channel's staging and active registers. On the same edge, each of the other three channels copies its staging register into its active register.
- R6: Mode 11 with control bit 2 = 0 copies every channel's staging register into its active register. It ignores the data bytes and the channel select.
- R7: Mode 11 with control bit 2 = 1 writes the new value into the staging and active registers of all four channels.
- R8: The new code is the high byte followed by bits [7:4] of the low byte. Bits [3:0] of the low byte have no effect.
- R9: With control bit 0 = 1, a write sets only the power-down mode, taken from high byte bits [7:6], and keeps the stored code. With control bit 0 = 0, a write stores the code and clears the power-down mode to 00. Both kinds of write follow the same load-mode paths.
- R10: `pwrDownFlag[i]` is 1 exactly when channel i's active power-down mode is nonzero.
- R11: While `wrStrobe` is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | One-cycle write strobe from the serial decoder |
| ctrlByte | input | 8 | Control byte of the write |
| hiByte | input | 8 | High data byte (code bits 11:4, or power-down mode in bits 7:6) |
| loByte | input | 8 | Low data byte (code bits 3:0 in bits 7:4) |
| strapAddr | input | 2 | Extended address strap pins, compared with control bits 7:6 |
| codeOut | output | 48 | Active codes, channel i at bits [12i+11:12i] |
| pdOut | output | 8 | Active power-down modes, channel i at bits [2i+1:2i] |
| pwrDownFlag | output | 4 | Per-channel powered-down indication |

## Verification
The bench stages different codes in several channels and then uses the synchronous-transfer mode and the replay broadcast. A bank that swapped the two register levels, or that moved the selected channel's stale staging value, would show a wrong code on some channel. A non-broadcast write with mismatched address bits is sent. A broadcast write is sent with address bits that deliberately mismatch. This catches a design that checks the straps in the wrong modes. Power-down-only writes are mixed with data writes to show that the stored code survives a power-down write and that the next data write clears the mode. A write whose low nibble is nonzero exposes a design that shifted the code by one nibble.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int SEL_W     = 2;
  localparam int CH_NUM    = 2 ** SEL_W;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    MODE_STORE = 2'b00,
    MODE_LOAD  = 2'b01,
    MODE_SYNC  = 2'b10,
    MODE_BCAST = 2'b11
  } loadMode_t;

  typedef struct packed {
    logic [CH_NUM-1:0] tempWr;
    logic [CH_NUM-1:0] dacWrNew;
    logic [CH_NUM-1:0] dacWrTemp;
    logic              pdOnly;
  } bankStrobe_t;
endpackage

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import quad_dac_pkg::*;
(
  input  logic                 wrStrobe,
  input  logic [BYTE_BITS-1:0] ctrlByte,
  input  logic [1:0]           strapAddr,
  output bankStrobe_t          strb
);
  loadMode_t         mode;
  logic [SEL_W-1:0]  sel;
  logic              addrOk;
  logic [CH_NUM-1:0] selOh;
  logic              unusedSpare;

  assign mode        = loadMode_t'(ctrlByte[5:4]);
  assign sel         = ctrlByte[2:1];
  assign addrOk      = (ctrlByte[7:6] == strapAddr);
  assign unusedSpare = ctrlByte[3];

  for (genvar g = 0; g < CH_NUM; g++) begin : g_sel
    assign selOh[g] = (sel == SEL_W'(g));
  end

  always_comb begin
    strb        = '0;
    strb.pdOnly = ctrlByte[0];
    if (wrStrobe) begin
      unique case (mode)
        MODE_STORE: if (addrOk) strb.tempWr = selOh;
        MODE_LOAD: if (addrOk) begin
          strb.tempWr   = selOh;
          strb.dacWrNew = selOh;
        end
        MODE_SYNC: if (addrOk) begin
          strb.tempWr    = selOh;
          strb.dacWrNew  = selOh;
          strb.dacWrTemp = ~selOh;
        end
        MODE_BCAST: begin
          if (ctrlByte[2]) begin
            strb.tempWr   = '1;
            strb.dacWrNew = '1;
          end else begin
            strb.dacWrTemp = '1;
          end
        end
        default: strb.tempWr = '0;
      endcase
    end
  end
endmodule

// File: rtl/quad_dac_datapath.sv
module quad_dac_datapath
  import quad_dac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int PD_W   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bankStrobe_t              strb,
  input  logic [BYTE_BITS-1:0]     hiByte,
  input  logic [BYTE_BITS-1:0]     loByte,
  output logic [CH_NUM*CODE_W-1:0] codeOut,
  output logic [CH_NUM*PD_W-1:0]   pdOut
);
  localparam int LO_USE  = CODE_W - BYTE_BITS;
  localparam int LO_SKIP = BYTE_BITS - LO_USE;

  logic [CODE_W-1:0]  newCode;
  logic [PD_W-1:0]    newPd;
  logic [LO_SKIP-1:0] unusedLo;

  assign newCode  = {hiByte, loByte[BYTE_BITS-1 -: LO_USE]};
  assign newPd    = hiByte[BYTE_BITS-1 -: PD_W];
  assign unusedLo = loByte[LO_SKIP-1:0];

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    logic [CODE_W-1:0] tCode, dCode;
    logic [PD_W-1:0]   tPd, dPd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tCode <= '0;
        tPd   <= '0;
        dCode <= '0;
        dPd   <= '0;
      end else begin
        if (strb.tempWr[g]) begin
          if (strb.pdOnly) begin
            tPd <= newPd;
          end else begin
            tCode <= newCode;
            tPd   <= '0;
          end
        end
        if (strb.dacWrNew[g]) begin
          if (strb.pdOnly) begin
            dPd <= newPd;
          end else begin
            dCode <= newCode;
            dPd   <= '0;
          end
        end else if (strb.dacWrTemp[g]) begin
          dCode <= tCode;
          dPd   <= tPd;
        end
      end
    end

    assign codeOut[g*CODE_W +: CODE_W] = dCode;
    assign pdOut[g*PD_W +: PD_W]       = dPd;
  end
endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
  import quad_dac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int PD_W   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrStrobe,
  input  logic [7:0]               ctrlByte,
  input  logic [7:0]               hiByte,
  input  logic [7:0]               loByte,
  input  logic [1:0]               strapAddr,
  output logic [CH_NUM*CODE_W-1:0] codeOut,
  output logic [CH_NUM*PD_W-1:0]   pdOut,
  output logic [CH_NUM-1:0]        pwrDownFlag
);
  bankStrobe_t strb;

  quad_dac_ctrl u_ctrl (
    .wrStrobe (wrStrobe),
    .ctrlByte (ctrlByte),
    .strapAddr(strapAddr),
    .strb     (strb)
  );

  quad_dac_datapath #(.CODE_W(CODE_W), .PD_W(PD_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .hiByte (hiByte),
    .loByte (loByte),
    .codeOut(codeOut),
    .pdOut  (pdOut)
  );

  for (genvar g = 0; g < CH_NUM; g++) begin : g_flag
    assign pwrDownFlag[g] = |pdOut[g*PD_W +: PD_W];
  end
endmodule

// File: rtl/quad_dac_regbank_chk.sv
module quad_dac_regbank_chk
  import quad_dac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int PD_W   = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrStrobe,
  input logic [7:0]               ctrlByte,
  input logic [7:0]               hiByte,
  input logic [7:0]               loByte,
  input logic [1:0]               strapAddr,
  input logic [CH_NUM*CODE_W-1:0] codeOut,
  input logic [CH_NUM*PD_W-1:0]   pdOut
);
  localparam int LO_USE = CODE_W - BYTE_BITS;

  logic [SEL_W-1:0]  lastSel;
  logic [CODE_W-1:0] selCode;
  logic [PD_W-1:0]   selPd;
  logic [CODE_W-1:0] inCode;
  logic              matchWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastSel <= '0;
    else       lastSel <= ctrlByte[2:1];
  end

  assign selCode = codeOut[lastSel*CODE_W +: CODE_W];
  assign selPd   = pdOut[lastSel*PD_W +: PD_W];
  assign inCode  = {hiByte, loByte[7 -: LO_USE]};
  assign matchWr = wrStrobe && (ctrlByte[7:6] == strapAddr);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> $stable(codeOut) && $stable(pdOut));

  assert_addr_ignore_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && ctrlByte[5:4] != 2'b11 && ctrlByte[7:6] != strapAddr)
      |=> $stable(codeOut) && $stable(pdOut));

  assert_store_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && ctrlByte[5:4] == 2'b00) |=> $stable(codeOut) && $stable(pdOut));

  assert_load_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (matchWr && ctrlByte[5:4] == 2'b01 && !ctrlByte[0]) |=> selCode == $past(inCode));

  assert_data_clears_pd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (matchWr && ctrlByte[5:4] == 2'b01 && !ctrlByte[0]) |=> selPd == '0);

  assert_bcast_fresh_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && ctrlByte[5:4] == 2'b11 && ctrlByte[2] && !ctrlByte[0])
      |=> codeOut == {CH_NUM{$past(inCode)}});
endmodule

bind quad_dac_regbank quad_dac_regbank_chk #(.CODE_W(CODE_W), .PD_W(PD_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .ctrlByte(ctrlByte),
  .hiByte(hiByte), .loByte(loByte), .strapAddr(strapAddr),
  .codeOut(codeOut), .pdOut(pdOut)
);

// File: tb/quad_dac_regbank_tb.sv
`timescale 1ns/1ps
module quad_dac_regbank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [7:0]  ctrlByte = '0, hiByte = '0, loByte = '0;
  logic [1:0]  strapAddr = 2'b10;
  logic [47:0] codeOut;
  logic [7:0]  pdOut;
  logic [3:0]  pwrDownFlag;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  quad_dac_regbank u_dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .ctrlByte(ctrlByte),
    .hiByte(hiByte), .loByte(loByte), .strapAddr(strapAddr),
    .codeOut(codeOut), .pdOut(pdOut), .pwrDownFlag(pwrDownFlag)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [47:0] codes;
    logic [7:0]  pd;
  } vec_t;

  // straps = 10; codes packed {ch3,ch2,ch1,ch0}
  localparam vec_t VECS [12] = '{
    '{8'h90, 8'h12, 8'h3F, 48'h000000000123, 8'h00},
    '{8'h82, 8'hAB, 8'hC0, 48'h000000000123, 8'h00},
    '{8'h84, 8'h45, 8'h6F, 48'h000000000123, 8'h00},
    '{8'h56, 8'hFF, 8'hFF, 48'h000000000123, 8'h00},
    '{8'hA6, 8'h78, 8'h9A, 48'h789456ABC123, 8'h00},
    '{8'h93, 8'h80, 8'h00, 48'h789456ABC123, 8'h08},
    '{8'h34, 8'hFE, 8'hDC, 48'hFEDFEDFEDFED, 8'h00},
    '{8'h80, 8'h01, 8'h20, 48'hFEDFEDFEDFED, 8'h00},
    '{8'h30, 8'h00, 8'h00, 48'hFEDFEDFED012, 8'h00},
    '{8'h35, 8'hC0, 8'h00, 48'hFEDFEDFED012, 8'hFF},
    '{8'h94, 8'h33, 8'h3F, 48'hFED333FED012, 8'hCF},
    '{8'h30, 8'h00, 8'h00, 48'hFED333FED012, 8'hCF}
  };
  localparam string ROW_TAG [12] = '{
    "R4 load one", "R3 store only", "R3 store only", "R2 address mismatch",
    "R5 sync transfer", "R9 power-down write", "R7 broadcast fresh",
    "R3 store only", "R6 broadcast replay", "R9 broadcast power-down",
    "R9 data clears mode", "R6 replay keeps modes"
  };

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] c, logic [7:0] h, logic [7:0] l);
    @(negedge clk);
    ctrlByte = c; hiByte = h; loByte = l; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  function automatic logic [3:0] flagsOf(logic [7:0] pd);
    logic [3:0] f;
    for (int i = 0; i < 4; i++) f[i] = |pd[2*i +: 2];
    return f;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset codes", codeOut, '0);
    check("R1 reset modes", {40'h0, pdOut}, '0);
    check("R10 reset flags", {44'h0, pwrDownFlag}, '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      doWrite(VECS[i].ctrl, VECS[i].hi, VECS[i].lo);
      check(ROW_TAG[i], codeOut, VECS[i].codes);
      check(ROW_TAG[i], {40'h0, pdOut}, {40'h0, VECS[i].pd});
      check("R10 flags", {44'h0, pwrDownFlag}, {44'h0, flagsOf(VECS[i].pd)});
    end

    // R8: low nibble of low byte has no effect
    doWrite(8'h90, 8'h5A, 8'h0F);
    check("R8 low nibble ignored", {36'h0, codeOut[11:0]}, {36'h0, 12'h5A0});
    doWrite(8'h90, 8'h5A, 8'h07);
    check("R8 low nibble ignored", {36'h0, codeOut[11:0]}, {36'h0, 12'h5A0});

    // R11: inputs move without strobe
    @(negedge clk);
    ctrlByte = 8'hB6; hiByte = 8'hFF; loByte = 8'hFF;
    repeat (3) @(negedge clk);
    check("R11 no strobe", codeOut, 48'hFED333FED5A0);

    // R1: reset mid-run clears everything
    rstN = 1'b0;
    #1;
    check("R1 async reset codes", codeOut, '0);
    check("R1 async reset modes", {40'h0, pdOut}, '0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: staging was cleared too; replay gives zeros
    doWrite(8'h30, 8'h00, 8'h00);
    check("R1 staging cleared", codeOut, '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule